// File: doc/BRIEF.md
# Write-Protected Supply Monitor Configuration Register

This block is a small register-bus slave that configures two supply-threshold monitors. Each monitor has an enable and a mode bit, and the mode bit sends a below-threshold event either to a reset request or to a non-maskable interrupt request. The configuration is guarded by a key register. The control register accepts a write only while the key register holds the unlock value, so stray software stores cannot switch a monitor off during a brown-out.

The two below-threshold inputs come from analog comparators outside the block and are already synchronized to the clock. The block passes each qualified event on as a per-monitor reset request level. It can instead produce a single-cycle interrupt pulse, which a reset-stretching sequencer and the system interrupt logic outside the block then use. Once a monitor is set to interrupt mode and enabled, it cannot be disarmed until the next reset.

Top module: `vdet_guard_regs`

## Requirements
- R1: While reset is asserted, and after its release, the key register reads 0x00. The control register also reads 0x00, `mon_rst_o` is 0 and `nmi_o` is 0.
- R2: A bus write of exactly 0x3C to the key register (address 0) unlocks the control register. The key register then reads 0x3C.
- R3: A bus write of any other value to the key register locks the control register. The key register then reads 0x00.
- R4: A write to the control register (address 1) while it is locked leaves its contents unchanged.
- R5: Control register layout: bit 7 is the monitor-2 enable and bit 6 is the monitor-2 mode. Bit 1 is the monitor-1 enable and bit 0 is the monitor-1 mode. All other bits read 0. Addresses 2 and 3 read 0x00.
- R6: With a monitor enabled and its mode bit at 0, its `mon_rst_o` bit equals the `below_i` bit sampled at the previous clock edge.
- R7: With a monitor enabled and its mode bit at 1, a 0-to-1 change of its `below_i` bit makes `nmi_o` high for exactly one cycle, starting after that edge. Its `mon_rst_o` bit stays 0.
- R8: A disabled monitor produces neither a reset request nor an interrupt, whatever its `below_i` bit does.
- R9: Once a monitor has both enable and mode at 1, writes cannot change its two bits until reset. The other monitor's bits stay writable.
- R10: `bus_rdata_o` is a combinational function of `bus_addr_i` and register state, valid in the same cycle.
- R11: After `rst_ni` rises, the registers stay in reset through two rising clock edges. A write takes effect from the third edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 key, 1 control) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| below_i | input | 2 | Synchronized below-threshold flags, bit 0 monitor 1, bit 1 monitor 2 |
| mon_rst_o | output | 2 | Per-monitor reset request |
| nmi_o | output | 1 | Non-maskable interrupt request pulse |

## Verification
Writes and both event outputs are registered. A bus write shows in a read, and a `below_i` change shows on `mon_rst_o` or `nmi_o`, right after the clock edge that samples it. Read data needs no edge at all. The bench drives inputs on the falling edge and checks 2 ns after the following rising edge, so each result is compared in the one cycle where it is due. It then drives the next step, which also shows that the interrupt pulse has ended. The release of reset is checked edge by edge, with a key write held through the second and third edges.

// File: rtl/vdet_pkg.sv
package vdet_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int NUM_MON   = 2;
  localparam logic [DATA_W-1:0] KEY_OPEN = 8'h3C;
  localparam logic [ADDR_W-1:0] A_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;

  // Bit positions are fixed by software-visible layout.
  function automatic int en_pos(input int mon);
    return (mon == 0) ? 1 : 7;
  endfunction

  function automatic int mode_pos(input int mon);
    return (mon == 0) ? 0 : 6;
  endfunction
endpackage

// File: rtl/vdet_rst_sync.sv
module vdet_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/vdet_key_lock.sv
module vdet_key_lock
  import vdet_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_we_i,
  input  logic [DATA_W-1:0] key_wdata_i,
  output logic              open_o
);
  logic open_q;
  logic open_d;

  always_comb begin
    open_d = (key_wdata_i == KEY_OPEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       open_q <= 1'b0;
    else if (key_we_i) open_q <= open_d;
  end

  assign open_o = open_q;
endmodule

// File: rtl/vdet_ctrl_reg.sv
module vdet_ctrl_reg
  import vdet_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic               open_i,
  input  logic [NUM_MON-1:0] wr_en_i,
  input  logic [NUM_MON-1:0] wr_mode_i,
  output logic [NUM_MON-1:0] en_o,
  output logic [NUM_MON-1:0] mode_o
);
  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    logic en_q, mode_q, en_d, mode_d, upd;

    // An armed interrupt path freezes both of its bits.
    always_comb begin
      upd    = ctrl_we_i & open_i & ~(en_q & mode_q);
      en_d   = wr_en_i[m];
      mode_d = wr_mode_i[m];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        mode_q <= 1'b0;
      end else if (upd) begin
        en_q   <= en_d;
        mode_q <= mode_d;
      end
    end

    assign en_o[m]   = en_q;
    assign mode_o[m] = mode_q;
  end
endmodule

// File: rtl/vdet_mon_event.sv
module vdet_mon_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic below_i,
  output logic rst_req_o,
  output logic nmi_pulse_o
);
  logic rst_q, rst_d;
  logic irq_lvl_q, irq_lvl_d;
  logic pulse_q, pulse_d;

  always_comb begin
    rst_d     = en_i & ~mode_i & below_i;
    irq_lvl_d = en_i &  mode_i & below_i;
    pulse_d   = irq_lvl_d & ~irq_lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q     <= 1'b0;
      irq_lvl_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      rst_q     <= rst_d;
      irq_lvl_q <= irq_lvl_d;
      pulse_q   <= pulse_d;
    end
  end

  assign rst_req_o   = rst_q;
  assign nmi_pulse_o = pulse_q;
endmodule

// File: rtl/vdet_guard_regs.sv
module vdet_guard_regs
  import vdet_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NUM_MON-1:0] below_i,
  output logic [NUM_MON-1:0] mon_rst_o,
  output logic               nmi_o
);
  logic               rst_n_core;
  logic               key_we, ctrl_we, key_open;
  logic [NUM_MON-1:0] wr_en, wr_mode, cfg_en, cfg_mode, mon_nmi;
  logic [DATA_W-1:0]  ctrl_rd;
  logic               unused_wdata;

  vdet_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n_core)
  );

  assign key_we  = bus_we_i & (bus_addr_i == A_KEY);
  assign ctrl_we = bus_we_i & (bus_addr_i == A_CTRL);
  assign unused_wdata = ^bus_wdata_i;

  for (genvar m = 0; m < NUM_MON; m++) begin : g_wr
    assign wr_en[m]   = bus_wdata_i[en_pos(m)];
    assign wr_mode[m] = bus_wdata_i[mode_pos(m)];
  end

  vdet_key_lock u_key (
    .clk_i(clk_i), .rst_ni(rst_n_core), .key_we_i(key_we),
    .key_wdata_i(bus_wdata_i), .open_o(key_open)
  );

  vdet_ctrl_reg u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_n_core), .ctrl_we_i(ctrl_we), .open_i(key_open),
    .wr_en_i(wr_en), .wr_mode_i(wr_mode), .en_o(cfg_en), .mode_o(cfg_mode)
  );

  for (genvar m = 0; m < NUM_MON; m++) begin : g_evt
    vdet_mon_event u_evt (
      .clk_i(clk_i), .rst_ni(rst_n_core), .en_i(cfg_en[m]), .mode_i(cfg_mode[m]),
      .below_i(below_i[m]), .rst_req_o(mon_rst_o[m]), .nmi_pulse_o(mon_nmi[m])
    );
  end

  assign nmi_o = |mon_nmi;

  always_comb begin
    ctrl_rd = '0;
    for (int m = 0; m < NUM_MON; m++) begin
      ctrl_rd[en_pos(m)]   = cfg_en[m];
      ctrl_rd[mode_pos(m)] = cfg_mode[m];
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_KEY:   bus_rdata_o = key_open ? KEY_OPEN : '0;
      A_CTRL:  bus_rdata_o = ctrl_rd;
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vdet_guard_chk.sv
module vdet_guard_chk
  import vdet_pkg::*;
(
  input logic               clk_i,
  input logic               rst_n_core,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [NUM_MON-1:0] below_i,
  input logic               key_open,
  input logic [DATA_W-1:0]  ctrl_rd,
  input logic [NUM_MON-1:0] mon_rst_o,
  input logic [NUM_MON-1:0] mon_nmi
);
  p_key_open_r2: assert property (@(posedge clk_i) disable iff (!rst_n_core)
    (bus_we_i && bus_addr_i == A_KEY && bus_wdata_i == KEY_OPEN) |=> key_open);

  p_key_close_r3: assert property (@(posedge clk_i) disable iff (!rst_n_core)
    (bus_we_i && bus_addr_i == A_KEY && bus_wdata_i != KEY_OPEN) |=> !key_open);

  p_lock_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n_core)
    (bus_we_i && bus_addr_i == A_CTRL && !key_open) |=> $stable(ctrl_rd));

  for (genvar m = 0; m < NUM_MON; m++) begin : g_chk
    p_rst_req_r6: assert property (@(posedge clk_i) disable iff (!rst_n_core)
      mon_rst_o[m] |-> $past(ctrl_rd[en_pos(m)] && !ctrl_rd[mode_pos(m)] && below_i[m]));

    p_nmi_single_r7: assert property (@(posedge clk_i) disable iff (!rst_n_core)
      mon_nmi[m] |=> !mon_nmi[m]);

    p_nmi_needs_arm_r8: assert property (@(posedge clk_i) disable iff (!rst_n_core)
      mon_nmi[m] |-> $past(ctrl_rd[en_pos(m)] && ctrl_rd[mode_pos(m)] && below_i[m]));

    p_arm_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_n_core)
      (ctrl_rd[en_pos(m)] && ctrl_rd[mode_pos(m)]) |=>
      (ctrl_rd[en_pos(m)] && ctrl_rd[mode_pos(m)]));
  end
endmodule

bind vdet_guard_regs vdet_guard_chk u_chk (
  .clk_i(clk_i), .rst_n_core(rst_n_core), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .below_i(below_i),
  .key_open(key_open), .ctrl_rd(ctrl_rd), .mon_rst_o(mon_rst_o), .mon_nmi(mon_nmi)
);

// File: tb/vdet_guard_regs_bench.sv
module vdet_guard_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] below;
  logic [1:0] mrst;
  logic       nmi;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vdet_guard_regs u_vdet_guard_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .below_i(below),
    .mon_rst_o(mrst), .nmi_o(nmi)
  );

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [1:0] a, input logic [7:0] d, input logic [1:0] b);
    @(negedge clk);
    we = w; addr = a; wdata = d; b = b; below = b;
  endtask

  // {req, we, addr, wdata, below, exp_rdata, exp_rst, exp_nmi}
  localparam int NV = 16;
  localparam logic [27:0] VEC [NV] = '{
    {4'd4,  1'b1, 2'd1, 8'h83, 2'b00, 8'h00, 2'b00, 1'b0}, // R4 locked write
    {4'd2,  1'b1, 2'd0, 8'h3C, 2'b00, 8'h3C, 2'b00, 1'b0}, // R2 unlock
    {4'd5,  1'b1, 2'd1, 8'h3E, 2'b00, 8'h02, 2'b00, 1'b0}, // R5 unused bits drop
    {4'd6,  1'b0, 2'd1, 8'h00, 2'b01, 8'h02, 2'b01, 1'b0}, // R6 reset request
    {4'd6,  1'b0, 2'd1, 8'h00, 2'b00, 8'h02, 2'b00, 1'b0}, // R6 follows input
    {4'd8,  1'b0, 2'd1, 8'h00, 2'b10, 8'h02, 2'b00, 1'b0}, // R8 disabled monitor
    {4'd5,  1'b1, 2'd1, 8'hC2, 2'b00, 8'hC2, 2'b00, 1'b0}, // R5 monitor-2 arm
    {4'd7,  1'b0, 2'd1, 8'h00, 2'b10, 8'hC2, 2'b00, 1'b1}, // R7 pulse
    {4'd7,  1'b0, 2'd1, 8'h00, 2'b10, 8'hC2, 2'b00, 1'b0}, // R7 single cycle
    {4'd7,  1'b0, 2'd1, 8'h00, 2'b00, 8'hC2, 2'b00, 1'b0}, // R7 quiet
    {4'd9,  1'b1, 2'd1, 8'h00, 2'b00, 8'hC0, 2'b00, 1'b0}, // R9 sticky arm
    {4'd3,  1'b1, 2'd0, 8'h55, 2'b00, 8'h00, 2'b00, 1'b0}, // R3 relock
    {4'd4,  1'b1, 2'd1, 8'h03, 2'b00, 8'hC0, 2'b00, 1'b0}, // R4 locked write
    {4'd5,  1'b0, 2'd2, 8'h00, 2'b00, 8'h00, 2'b00, 1'b0}, // R5 empty address
    {4'd5,  1'b0, 2'd3, 8'h00, 2'b00, 8'h00, 2'b00, 1'b0}, // R5 empty address
    {4'd8,  1'b0, 2'd1, 8'h00, 2'b11, 8'hC0, 2'b00, 1'b1}  // R8 m1 off, m2 armed
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = 2'd0; wdata = 8'h00; below = 2'b00;
    repeat (3) @(posedge clk);
    #2;
    // R1 state while in reset
    chk(1, "key in reset", rdata, 8'h00);
    chk(1, "outputs in reset", {5'b0, mrst, nmi}, 8'h00);
    // R11: hold a key write across the release
    @(negedge clk);
    rst_n = 1'b1; we = 1'b1; addr = 2'd0; wdata = 8'h3C;
    @(posedge clk); #2; chk(11, "edge 1 after release", rdata, 8'h00);
    @(posedge clk); #2; chk(11, "edge 2 after release", rdata, 8'h00);
    @(posedge clk); #2; chk(11, "edge 3 after release", rdata, 8'h3C);
    drive(1'b1, 2'd0, 8'h00, 2'b00);
    @(posedge clk); #2; chk(3, "relock with 00", rdata, 8'h00);
    drive(1'b0, 2'd1, 8'h00, 2'b00);
    #1; chk(1, "ctrl after release", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      drive(v[23], v[22:21], v[20:13], v[12:11]);
      @(posedge clk); #2;
      chk(int'(v[27:24]), "vector rdata", rdata, v[10:3]);
      chk(int'(v[27:24]), "vector mon_rst", {6'b0, mrst}, {6'b0, v[2:1]});
      chk(int'(v[27:24]), "vector nmi", {7'b0, nmi}, {7'b0, v[0]});
    end

    // R10: read data follows address with no clock edge
    @(negedge clk);
    we = 1'b0; below = 2'b00; addr = 2'd1;
    #1; chk(10, "comb read ctrl", rdata, 8'hC0);
    addr = 2'd0;
    #1; chk(10, "comb read key", rdata, 8'h00);

    // R1: reset mid-run clears the armed monitor
    rst_n = 1'b0;
    addr = 2'd1;
    #1; chk(1, "ctrl cleared by reset", rdata, 8'h00);
    chk(1, "outputs cleared by reset", {5'b0, mrst, nmi}, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #2;
    chk(1, "ctrl after second release", rdata, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule